// File: doc/BRIEF.md
# Multi-Core Reset and Power-Up Controller

This block is a memory-mapped register bank that governs a four-core processor cluster. Software turns the secondary cores (1, 2 and 3) on and off, requests per-core resets, and fires two peripheral (display unit) resets, all through one control register. A set of general-purpose registers holds each secondary core's entry address and start argument. These are driven out continuously so that the core start logic can pick them up when it sees a start pulse.

Control actions are edge-triggered on the stored value. Each control write is XOR-compared against the current contents, and only bits that actually flip produce an action. Start, stop and reset requests are one-cycle pulses. A core's reset bit stays as written until that core returns its acknowledge input. The display reset bits never hold a 1.

Access is a single 32-bit word port with a 4 KiB window. The register index is the byte offset divided by four. Unaligned or out-of-range accesses are flagged on `accessErr` and have no effect.

Top module: `coreResetCtl`

## Requirements
- R1: After reset, the control register (offset 0x00) reads 0x521, offset 0x08 reads 0x1, offset 0x10 reads 0x1F, and every other implemented register (offsets up to 0x3C) reads 0. All outputs are inactive.
- R2: A read with `rdEn` high returns, in the same cycle on `rdData`, the register at index `addr[11:2]`. Sixteen registers are implemented at indices 0 to 15.
- R3: An access to an index of 16 or more, or with `addr[1:0]` not zero, raises `accessErr` in that cycle. Such a read returns 0, and such a write changes no register.
- R4: A control write that flips the enable bit of core k (bit 21+k, k = 1..3) from 0 to 1 gives a one-cycle `coreStart[k]` pulse in the cycle after the write. Core k's entry address and argument are always presented from offsets 0x20/0x24 (core 1), 0x28/0x2C (core 2) and 0x30/0x34 (core 3) on `entryAddr`/`entryArg` slice k-1.
- R5: A control write that flips an enable bit from 1 to 0 gives a one-cycle `coreStop[k]` pulse. A write that leaves an enable bit unchanged gives no start or stop pulse.
- R6: A control write that flips the reset bit of core k (bit 13+k, k = 0..3) in either direction gives a one-cycle `coreReset[k]` pulse, and the bit reads back as written.
- R7: When the enable bit of core k flips in a write, no `coreReset[k]` pulse is issued for that core in that write. All actions caused by one write appear together in the same cycle.
- R8: `coreAck[k]` high for a cycle clears control bit 13+k from the next cycle on. A control write in the same cycle takes priority, and the written value is kept.
- R9: Writing 1 to control bit 3 or bit 12 gives a one-cycle pulse on `dispReset[0]` or `dispReset[1]` respectively, and that bit reads back as 0.
- R10: `coreEnable[k]` always equals control bit 21+k.
- R11: A write to any register other than the control register stores the written value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 12 | Byte offset in the window |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, same cycle as rdEn |
| accessErr | output | 1 | Bad offset or misaligned access |
| coreAck | input | 4 | Per-core completion acknowledge |
| coreEnable | output | 3 | Enable level, cores 3..1 |
| coreStart | output | 3 | Start pulse, cores 3..1 |
| coreStop | output | 3 | Shutdown pulse, cores 3..1 |
| coreReset | output | 4 | Reset pulse, cores 3..0 |
| entryAddr | output | 96 | Entry addresses, core 1 in bits 31:0 |
| entryArg | output | 96 | Start arguments, core 1 in bits 31:0 |
| dispReset | output | 2 | Display unit reset pulses |

## Verification
The hardest case to reach from the ports is a control write landing in the same cycle as the acknowledge that would clear the reset bit being written. The bench first leaves a reset bit set. It then drives `coreAck` and `wrEn` on the same falling edge and reads the bit back to confirm that the write won. A second acknowledge alone must then clear the bit. A write that flips an enable bit and a reset bit together is also used, to show that the enable change suppresses that core's reset pulse while the other cores' resets still fire in the same cycle.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 12;
  localparam int NUM_REGS   = 16;
  localparam int IDX_W      = $clog2(NUM_REGS);
  localparam int CORES      = 4;
  localparam int NUM_DISP   = 2;
  localparam int RST_LSB    = 13;   // core k reset at RST_LSB + k
  localparam int EN_LSB     = 21;   // core k enable at EN_LSB + k
  localparam int DISP_LO    = 3;
  localparam int DISP_HI    = 12;
  localparam int ENTRY_BASE = 8;    // index of core 1 entry address
  localparam int CTRL_IDX   = 0;

  typedef struct packed {
    logic              regWr;
    logic              rdHit;
    logic [IDX_W-1:0]  regIdx;
    logic [DATA_W-1:0] storeVal;
    logic [CORES-1:1]  startReq;
    logic [CORES-1:1]  stopReq;
    logic [CORES-1:0]  rstReq;
    logic [NUM_DISP-1:0] dispReq;
  } strobe_t;

  function automatic logic [DATA_W-1:0] resetValue(input int idx);
    case (idx)
      0:       return 32'h0000_0521;
      2:       return 32'h0000_0001;
      4:       return 32'h0000_001F;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/rstctl_ctrl.sv
module rstctl_ctrl
  import rstctl_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] ctrlNow,
  output strobe_t           strb,
  output logic              accessErr
);
  localparam int FULL_IDX_W = ADDR_W - 2;

  logic [FULL_IDX_W-1:0] idxFull;
  logic                  aligned;
  logic                  inRange;
  logic                  hit;
  logic                  ctrlWr;
  logic [DATA_W-1:0]     chg;
  logic [CORES-1:1]      enChg;

  assign idxFull   = addr[ADDR_W-1:2];
  assign aligned   = (addr[1:0] == 2'b00);
  assign inRange   = (int'(idxFull) < NUM_REGS);
  assign hit       = aligned && inRange;
  assign accessErr = (wrEn || rdEn) && !hit;
  assign ctrlWr    = wrEn && hit && (int'(idxFull) == CTRL_IDX);
  assign chg       = ctrlNow ^ wrData;

  for (genvar k = 1; k < CORES; k++) begin : g_en
    assign enChg[k]         = chg[EN_LSB + k];
    assign strb.startReq[k] = ctrlWr && enChg[k] && wrData[EN_LSB + k];
    assign strb.stopReq[k]  = ctrlWr && enChg[k] && !wrData[EN_LSB + k];
  end

  for (genvar k = 0; k < CORES; k++) begin : g_rst
    if (k == 0) begin : g_boot
      assign strb.rstReq[k] = ctrlWr && chg[RST_LSB + k];
    end else begin : g_sec
      assign strb.rstReq[k] = ctrlWr && chg[RST_LSB + k] && !enChg[k];
    end
  end

  assign strb.dispReq[0] = ctrlWr && chg[DISP_LO];
  assign strb.dispReq[1] = ctrlWr && chg[DISP_HI];

  always_comb begin
    strb.storeVal = wrData;
    if (ctrlWr) begin
      strb.storeVal[DISP_LO] = 1'b0;
      strb.storeVal[DISP_HI] = 1'b0;
    end
  end

  assign strb.regWr  = wrEn && hit;
  assign strb.rdHit  = rdEn && hit;
  assign strb.regIdx = idxFull[IDX_W-1:0];
endmodule

// File: rtl/rstctl_regs.sv
module rstctl_regs
  import rstctl_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strb,
  input  logic [CORES-1:0]            coreAck,
  output logic [DATA_W-1:0]           ctrlNow,
  output logic [DATA_W-1:0]           rdData,
  output logic [CORES-1:1]            coreEnable,
  output logic [CORES-1:1]            coreStart,
  output logic [CORES-1:1]            coreStop,
  output logic [CORES-1:0]            coreReset,
  output logic [(CORES-1)*DATA_W-1:0] entryAddr,
  output logic [(CORES-1)*DATA_W-1:0] entryArg,
  output logic [NUM_DISP-1:0]         dispReset
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= resetValue(i);
    end else begin
      for (int k = 0; k < CORES; k++) begin
        if (coreAck[k]) regs[CTRL_IDX][RST_LSB + k] <= 1'b0;
      end
      if (strb.regWr) regs[strb.regIdx] <= strb.storeVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreStart <= '0;
      coreStop  <= '0;
      coreReset <= '0;
      dispReset <= '0;
    end else begin
      coreStart <= strb.startReq;
      coreStop  <= strb.stopReq;
      coreReset <= strb.rstReq;
      dispReset <= strb.dispReq;
    end
  end

  assign ctrlNow = regs[CTRL_IDX];
  assign rdData  = strb.rdHit ? regs[strb.regIdx] : '0;

  for (genvar k = 1; k < CORES; k++) begin : g_core
    assign coreEnable[k] = regs[CTRL_IDX][EN_LSB + k];
    assign entryAddr[(k-1)*DATA_W +: DATA_W] = regs[ENTRY_BASE + 2*(k-1)];
    assign entryArg[(k-1)*DATA_W +: DATA_W]  = regs[ENTRY_BASE + 2*(k-1) + 1];
  end
endmodule

// File: rtl/coreResetCtl.sv
module coreResetCtl
  import rstctl_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  wrEn,
  input  logic                                  rdEn,
  input  logic [rstctl_pkg::ADDR_W-1:0]         addr,
  input  logic [rstctl_pkg::DATA_W-1:0]         wrData,
  output logic [rstctl_pkg::DATA_W-1:0]         rdData,
  output logic                                  accessErr,
  input  logic [rstctl_pkg::CORES-1:0]          coreAck,
  output logic [rstctl_pkg::CORES-1:1]          coreEnable,
  output logic [rstctl_pkg::CORES-1:1]          coreStart,
  output logic [rstctl_pkg::CORES-1:1]          coreStop,
  output logic [rstctl_pkg::CORES-1:0]          coreReset,
  output logic [(rstctl_pkg::CORES-1)*rstctl_pkg::DATA_W-1:0] entryAddr,
  output logic [(rstctl_pkg::CORES-1)*rstctl_pkg::DATA_W-1:0] entryArg,
  output logic [rstctl_pkg::NUM_DISP-1:0]       dispReset
);
  strobe_t           strb;
  logic [DATA_W-1:0] ctrlNow;

  rstctl_ctrl u_ctrl (
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .addr      (addr),
    .wrData    (wrData),
    .ctrlNow   (ctrlNow),
    .strb      (strb),
    .accessErr (accessErr)
  );

  rstctl_regs u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .coreAck    (coreAck),
    .ctrlNow    (ctrlNow),
    .rdData     (rdData),
    .coreEnable (coreEnable),
    .coreStart  (coreStart),
    .coreStop   (coreStop),
    .coreReset  (coreReset),
    .entryAddr  (entryAddr),
    .entryArg   (entryArg),
    .dispReset  (dispReset)
  );
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk
  import rstctl_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic                rdEn,
  input logic [DATA_W-1:0]   rdData,
  input logic                accessErr,
  input logic [CORES-1:1]    coreEnable,
  input logic [CORES-1:1]    coreStart,
  input logic [CORES-1:1]    coreStop,
  input logic [CORES-1:0]    coreReset,
  input logic [NUM_DISP-1:0] dispReset
);
  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && accessErr) |-> (rdData == '0));                         // R3
  AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (|coreStart) |-> $past(wrEn));                                   // R4
  AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    ((coreStart & ~coreEnable) == '0));                              // R4
  AST_STOP_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    ((coreStop & coreEnable) == '0));                                // R5
  AST_RESET_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (|coreReset) |-> $past(wrEn));                                   // R6
  AST_NO_RESET_ON_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    ((coreReset[CORES-1:1] & (coreStart | coreStop)) == '0));        // R7
  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn) |-> $stable(coreEnable));                           // R10
  AST_DISP_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (|dispReset) |-> $past(wrEn));                                   // R9
endmodule

bind coreResetCtl rstctl_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .rdData     (rdData),
  .accessErr  (accessErr),
  .coreEnable (coreEnable),
  .coreStart  (coreStart),
  .coreStop   (coreStop),
  .coreReset  (coreReset),
  .dispReset  (dispReset)
);

// File: tb/tb_coreResetCtl.sv
`timescale 1ns/1ps
module tb_coreResetCtl;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn, rdEn;
  logic [11:0] addr;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic        accessErr;
  logic [3:0]  coreAck;
  logic [3:1]  coreEnable, coreStart, coreStop;
  logic [3:0]  coreReset;
  logic [95:0] entryAddr, entryArg;
  logic [1:0]  dispReset;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [3:1]  seenStart, seenStop;
  logic [3:0]  seenReset;
  logic [1:0]  seenDisp;
  logic        seenErr;
  logic [31:0] expCtrl;
  logic [31:0] rv;

  always #4 clk = ~clk;

  coreResetCtl dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .accessErr(accessErr),
    .coreAck(coreAck), .coreEnable(coreEnable), .coreStart(coreStart),
    .coreStop(coreStop), .coreReset(coreReset), .entryAddr(entryAddr),
    .entryArg(entryArg), .dispReset(dispReset)
  );

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [11:0] a, input logic [31:0] d, input logic [3:0] ack = 4'b0);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d; coreAck = ack;
    #1 seenErr = accessErr;
    @(negedge clk);
    wrEn = 1'b0; coreAck = 4'b0;
    seenStart = coreStart; seenStop = coreStop;
    seenReset = coreReset; seenDisp = dispReset;
  endtask

  task automatic readReg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData; seenErr = accessErr;
    rdEn = 1'b0;
  endtask

  task automatic pulseAck(input logic [3:0] m);
    @(negedge clk); coreAck = m;
    @(negedge clk); coreAck = 4'b0;
  endtask

  task automatic tReset();
    readReg(12'h000, rv); check("R1 ctrl", rv, 32'h521);
    readReg(12'h004, rv); check("R1 idx1", rv, 0);
    readReg(12'h008, rv); check("R1 status", rv, 32'h1);
    readReg(12'h010, rv); check("R1 mask", rv, 32'h1F);
    readReg(12'h03C, rv); check("R1 last", rv, 0);
    check("R1 outputs", {coreEnable, coreStart, coreStop, coreReset, dispReset}, 0);
    check("R10 enable reset", coreEnable, 3'b000);
  endtask

  task automatic tGpr();
    for (int i = 0; i < 6; i++) writeReg(12'h020 + 12'(4*i), 32'hA000_0000 + 32'(i));
    readReg(12'h024, rv); check("R2 readback 0x24", rv, 32'hA000_0001);
    readReg(12'h034, rv); check("R11 readback 0x34", rv, 32'hA000_0005);
    check("R4 entryAddr", entryAddr, {32'hA000_0004, 32'hA000_0002, 32'hA000_0000});
    check("R4 entryArg", entryArg, {32'hA000_0005, 32'hA000_0003, 32'hA000_0001});
    writeReg(12'h014, 32'h1234_5678);
    readReg(12'h014, rv); check("R11 plain store", rv, 32'h1234_5678);
  endtask

  task automatic tBad();
    writeReg(12'h040, 32'hDEAD_BEEF); check("R3 write err", seenErr, 1'b1);
    readReg(12'h040, rv); check("R3 read zero", rv, 0); check("R3 read err", seenErr, 1'b1);
    writeReg(12'h022, 32'hFFFF_FFFF); check("R3 misaligned err", seenErr, 1'b1);
    readReg(12'h020, rv); check("R3 write ignored", rv, 32'hA000_0000);
    check("R3 no err good read", seenErr, 1'b0);
    readReg(12'h000, rv); check("R3 ctrl untouched", rv, 32'h521);
  endtask

  task automatic tStartStop();
    expCtrl = 32'h521 | (32'h1 << 22);
    writeReg(12'h000, expCtrl);
    check("R4 start core1", seenStart, 3'b001);
    check("R4 no stop/reset", {seenStop, seenReset}, 0);
    check("R10 enable level", coreEnable, 3'b001);
    readReg(12'h000, rv); check("R4 ctrl readback", rv, expCtrl);
    writeReg(12'h000, expCtrl);
    check("R5 same value no pulse", {seenStart, seenStop, seenReset}, 0);
    expCtrl = 32'h521;
    writeReg(12'h000, expCtrl);
    check("R5 stop core1", seenStop, 3'b001);
    check("R5 no start", seenStart, 3'b000);
    check("R10 enable low", coreEnable, 3'b000);
  endtask

  task automatic tMulti();
    expCtrl = 32'h521 | (32'h3 << 23) | (32'h1 << 13) | (32'h1 << 15);
    writeReg(12'h000, expCtrl);
    check("R7 starts together", seenStart, 3'b110);
    check("R7 core2 reset suppressed", seenReset, 4'b0001);
    readReg(12'h000, rv); check("R6 bits held", rv, expCtrl);
    pulseAck(4'b0001);
    expCtrl[13] = 1'b0;
    readReg(12'h000, rv); check("R8 ack core0 clears", rv, expCtrl);
    pulseAck(4'b0100);
    expCtrl[15] = 1'b0;
    readReg(12'h000, rv); check("R8 ack core2 clears", rv, expCtrl);
  endtask

  task automatic tResetBits();
    expCtrl[14] = 1'b1;
    writeReg(12'h000, expCtrl);
    check("R6 reset core1 rise", seenReset, 4'b0010);
    readReg(12'h000, rv); check("R6 bit14 kept", rv, expCtrl);
    writeReg(12'h000, expCtrl, 4'b0010);
    check("R8 no pulse on equal write", seenReset, 4'b0000);
    readReg(12'h000, rv); check("R8 write beats ack", rv, expCtrl);
    pulseAck(4'b0010);
    expCtrl[14] = 1'b0;
    readReg(12'h000, rv); check("R8 lone ack clears", rv, expCtrl);
    expCtrl[16] = 1'b1;
    writeReg(12'h000, expCtrl);
    expCtrl[16] = 1'b0;
    writeReg(12'h000, expCtrl);
    check("R6 reset core3 on fall", seenReset, 4'b1000);
  endtask

  task automatic tDisp();
    writeReg(12'h000, expCtrl | (32'h1 << 3) | (32'h1 << 12));
    check("R9 both display resets", seenDisp, 2'b11);
    readReg(12'h000, rv); check("R9 bits read clear", rv, expCtrl);
    writeReg(12'h000, expCtrl | (32'h1 << 12));
    check("R9 high unit only", seenDisp, 2'b10);
    @(negedge clk);
    check("R9 pulse one cycle", dispReset, 2'b00);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; addr = '0; wrData = '0; coreAck = '0;
    seenStart = '0; seenStop = '0; seenReset = '0; seenDisp = '0; seenErr = 1'b0;
    expCtrl = 32'h521; rv = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tGpr();
    tBad();
    tStartStop();
    tMulti();
    tResetBits();
    tDisp();
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule